// File: doc/BRIEF.md
# AHB Address Decoder with Built-in Default Subordinate

This block turns the address of an AHB address phase into a set of one-hot subordinate select lines. The address map is a parameter table of regions. Every region is a whole number of kilobytes long and starts on a 1KB boundary. Each region drives its own select output. A system can wire two or more of those outputs to one subordinate, which then needs no high-order decode of its own.

Addresses that fall outside every region go to a small default subordinate inside the block. It terminates those accesses with a defined response, so a stray access never stalls the bus. Where regions overlap, the lowest-indexed region wins. The integrator can ask elaboration to reject overlaps altogether. Arbitration, multiple managers and the return-data multiplexing are outside this block.

Top module: `ahb_addr_decoder`

## Requirements
- R1: Select output `hsel[i]` is high in the same cycle that `haddr` lies in [base_i, base_i + size_i*1024). The default map places region 0 at 0x0000_0000 (4KB), region 1 at 0x0000_0800 (4KB), region 2 at 0x0001_0000 (1KB) and region 3 at 0x0002_0000 (2KB).
- R2: Addresses within the same 1KB block always decode to the same select, so a burst that stays inside a 1KB block keeps one target.
- R3: When no region contains `haddr`, `hsel_dflt` is high and every bit of `hsel` is low.
- R4: When several regions contain `haddr`, only the select of the lowest-indexed region is high. In the default map, 0x0800 to 0x0FFF selects region 0.
- R5: Exactly one of `hsel` and `hsel_dflt` is high in every cycle after reset.
- R6: A default-subordinate transfer with `htrans` IDLE (2'b00) or BUSY (2'b01), accepted while `hready` is high, receives a zero-wait OKAY: in the following cycle `hreadyout_dflt`=1 and `hresp_dflt`=0.
- R7: A default-subordinate transfer with `htrans` NONSEQ (2'b10) or SEQ (2'b11), accepted while `hready` is high, receives a two-cycle ERROR response. In the first response cycle `hreadyout_dflt`=0 and `hresp_dflt`=1 (ERROR). In the second, `hreadyout_dflt`=1 and `hresp_dflt`=1. After that the outputs return to OKAY unless a new error transfer was accepted in the second cycle.
- R8: A NONSEQ or SEQ presented to the default subordinate while `hready` is low starts no transfer: the next cycle still shows `hreadyout_dflt`=1 and `hresp_dflt`=0.
- R9: The selects are a pure function of `haddr` and do not depend on `htrans` or `hready`.
- R10: During and directly after reset, `hreadyout_dflt`=1 and `hresp_dflt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low asynchronous reset |
| haddr | input | ADDR_W | Address-phase address |
| htrans | input | 2 | Transfer type (IDLE, BUSY, NONSEQ, SEQ) |
| hready | input | 1 | High when the previous data phase completes this cycle |
| hsel | output | N_REG | One select per region |
| hsel_dflt | output | 1 | Select of the internal default subordinate |
| hreadyout_dflt | output | 1 | Default subordinate ready response |
| hresp_dflt | output | 1 | Default subordinate response, 0 OKAY, 1 ERROR |

## Verification
The bench probes the first and last word of each region and the first word past each region's end. An off-by-one in the end comparison would either select the region one block too far or drop its top block. It also drives addresses into the overlap of regions 0 and 1: a wrong priority would raise region 1's select or raise both selects. On the default subordinate, it issues error transfers back to back, sends a request while `hready` is low, and sends BUSY. These cases expose a responder that shortens or stretches the two-cycle ERROR, one that starts a transfer during a stall, or one that raises ERROR for non-transfers.

// File: rtl/ahb_dec_pkg.sv
package ahb_dec_pkg;

   localparam logic [1:0] TRANS_IDLE   = 2'b00;
   localparam logic [1:0] TRANS_BUSY   = 2'b01;
   localparam logic [1:0] TRANS_NONSEQ = 2'b10;
   localparam logic [1:0] TRANS_SEQ    = 2'b11;

   localparam logic RESP_OKAY  = 1'b0;
   localparam logic RESP_ERROR = 1'b1;

   // 1KB decode granule
   localparam int unsigned GRAN_LSB = 10;

   typedef enum logic [1:0] {
      DS_IDLE = 2'b00,
      DS_ERR1 = 2'b01,
      DS_ERR2 = 2'b10
   } dflt_state_e;

endpackage

// File: rtl/ahb_region_match.sv
module ahb_region_match
   import ahb_dec_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned N_REG  = 4,
   parameter int unsigned KB_W   = 16,
   parameter logic [N_REG-1:0][ADDR_W-1:0] REG_BASE = '0,
   parameter logic [N_REG-1:0][KB_W-1:0]   REG_KB   = '1
) (
   input  logic [ADDR_W-1:0] haddr,
   output logic [N_REG-1:0]  hit
);

   localparam int unsigned BLK_W = ADDR_W - GRAN_LSB;

   logic [BLK_W-1:0] blk;
   assign blk = haddr[ADDR_W-1:GRAN_LSB];

   for (genvar i = 0; i < N_REG; i++) begin : g_cmp
      localparam logic [BLK_W:0] LO = {1'b0, REG_BASE[i][ADDR_W-1:GRAN_LSB]};
      localparam logic [BLK_W:0] HI = LO + (BLK_W+1)'(REG_KB[i]);

      if (REG_BASE[i][GRAN_LSB-1:0] != '0) begin : g_bad_align
         $error("region %0d base is not 1KB aligned", i);
      end
      if (REG_KB[i] == '0) begin : g_bad_size
         $error("region %0d is smaller than 1KB", i);
      end
      if (HI > (BLK_W+1)'(1) << BLK_W) begin : g_bad_end
         $error("region %0d runs past the top of the address space", i);
      end

      assign hit[i] = ({1'b0, blk} >= LO) && ({1'b0, blk} < HI);
   end

endmodule

// File: rtl/ahb_sel_priority.sv
module ahb_sel_priority #(
   parameter int unsigned N_REG = 4
) (
   input  logic [N_REG-1:0] hit,
   output logic [N_REG-1:0] sel,
   output logic             sel_dflt
);

   // a region's select is blocked by any lower-indexed hit
   logic [N_REG:0] blocked;
   assign blocked[0] = 1'b0;

   for (genvar i = 0; i < N_REG; i++) begin : g_chain
      assign sel[i]       = hit[i] & ~blocked[i];
      assign blocked[i+1] = blocked[i] | hit[i];
   end

   assign sel_dflt = ~blocked[N_REG];

endmodule

// File: rtl/ahb_dflt_sub.sv
module ahb_dflt_sub
   import ahb_dec_pkg::*;
(
   input  logic       hclk,
   input  logic       hresetn,
   input  logic       hsel,
   input  logic [1:0] htrans,
   input  logic       hready,
   output logic       hreadyout,
   output logic       hresp
);

   dflt_state_e st_q, st_d;
   logic        accept_err;

   // only NONSEQ/SEQ (htrans[1] set) in a completed address phase count
   assign accept_err = hsel & hready & htrans[1];

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         DS_IDLE: st_d = accept_err ? DS_ERR1 : DS_IDLE;
         DS_ERR1: st_d = DS_ERR2;
         DS_ERR2: st_d = accept_err ? DS_ERR1 : DS_IDLE;
         default: st_d = DS_IDLE;
      endcase
   end

   always_ff @(posedge hclk or negedge hresetn) begin
      if (!hresetn) st_q <= DS_IDLE;
      else          st_q <= st_d;
   end

   assign hreadyout = (st_q != DS_ERR1);
   assign hresp     = (st_q == DS_IDLE) ? RESP_OKAY : RESP_ERROR;

   // R7
   err_first_chk: assert property (@(posedge hclk) disable iff (!hresetn)
      (hsel && hready && htrans[1]) |=> (!hreadyout && hresp));

   // R7
   err_second_chk: assert property (@(posedge hclk) disable iff (!hresetn)
      (!hreadyout) |=> (hreadyout && hresp));

   // R6
   okay_chk: assert property (@(posedge hclk) disable iff (!hresetn)
      (hsel && hready && !htrans[1] && hreadyout) |=> (hreadyout && !hresp));

   // R8
   stall_chk: assert property (@(posedge hclk) disable iff (!hresetn)
      (!hready && hreadyout && !hresp) |=> (hreadyout && !hresp));

endmodule

// File: rtl/ahb_addr_decoder.sv
module ahb_addr_decoder
   import ahb_dec_pkg::*;
#(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned N_REG         = 4,
   parameter int unsigned KB_W          = 16,
   parameter bit          ALLOW_OVERLAP = 1'b1,
   parameter logic [N_REG-1:0][ADDR_W-1:0] REG_BASE = {
      32'h0002_0000, 32'h0001_0000, 32'h0000_0800, 32'h0000_0000},
   parameter logic [N_REG-1:0][KB_W-1:0] REG_KB = {
      16'd2, 16'd1, 16'd4, 16'd4}
) (
   input  logic              hclk,
   input  logic              hresetn,
   input  logic [ADDR_W-1:0] haddr,
   input  logic [1:0]        htrans,
   input  logic              hready,
   output logic [N_REG-1:0]  hsel,
   output logic              hsel_dflt,
   output logic              hreadyout_dflt,
   output logic              hresp_dflt
);

   localparam int unsigned BLK_W = ADDR_W - GRAN_LSB;

   function automatic int unsigned count_overlaps();
      int unsigned n = 0;
      for (int a = 0; a < N_REG; a++) begin
         for (int b = a + 1; b < N_REG; b++) begin
            logic [BLK_W:0] lo_a, hi_a, lo_b, hi_b;
            lo_a = {1'b0, REG_BASE[a][ADDR_W-1:GRAN_LSB]};
            hi_a = lo_a + (BLK_W+1)'(REG_KB[a]);
            lo_b = {1'b0, REG_BASE[b][ADDR_W-1:GRAN_LSB]};
            hi_b = lo_b + (BLK_W+1)'(REG_KB[b]);
            if (lo_a < hi_b && lo_b < hi_a) n++;
         end
      end
      return n;
   endfunction

   localparam int unsigned N_OVERLAP = count_overlaps();

   if (ADDR_W <= GRAN_LSB) begin : g_bad_width
      $error("address width must exceed the 1KB granule");
   end
   if (N_REG < 1) begin : g_bad_count
      $error("at least one region is required");
   end
   if (!ALLOW_OVERLAP && N_OVERLAP != 0) begin : g_overlap
      $error("%0d overlapping region pairs in the address map", N_OVERLAP);
   end

   logic [N_REG-1:0] hit;

   ahb_region_match #(
      .ADDR_W  (ADDR_W),
      .N_REG   (N_REG),
      .KB_W    (KB_W),
      .REG_BASE(REG_BASE),
      .REG_KB  (REG_KB)
   ) u_match (
      .haddr(haddr),
      .hit  (hit)
   );

   ahb_sel_priority #(
      .N_REG(N_REG)
   ) u_prio (
      .hit     (hit),
      .sel     (hsel),
      .sel_dflt(hsel_dflt)
   );

   ahb_dflt_sub u_dflt (
      .hclk     (hclk),
      .hresetn  (hresetn),
      .hsel     (hsel_dflt),
      .htrans   (htrans),
      .hready   (hready),
      .hreadyout(hreadyout_dflt),
      .hresp    (hresp_dflt)
   );

   // R5
   sel_onehot_chk: assert property (@(posedge hclk) disable iff (!hresetn)
      $countones({hsel, hsel_dflt}) == 1);

   // R9
   sel_addr_only_chk: assert property (@(posedge hclk) disable iff (!hresetn)
      $stable(haddr) |-> $stable({hsel, hsel_dflt}));

   // R3
   dflt_excl_chk: assert property (@(posedge hclk) disable iff (!hresetn)
      hsel_dflt |-> (hsel == '0));

endmodule

// File: tb/tb_ahb_addr_decoder.sv
module tb_ahb_addr_decoder;

   logic        hclk = 1'b0;
   logic        hresetn = 1'b0;
   logic [31:0] haddr = '0;
   logic [1:0]  htrans = 2'b00;
   logic        hready = 1'b1;
   logic [3:0]  hsel;
   logic        hsel_dflt;
   logic        hreadyout_dflt;
   logic        hresp_dflt;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 hclk = ~hclk;

   ahb_addr_decoder dut (
      .hclk          (hclk),
      .hresetn       (hresetn),
      .haddr         (haddr),
      .htrans        (htrans),
      .hready        (hready),
      .hsel          (hsel),
      .hsel_dflt     (hsel_dflt),
      .hreadyout_dflt(hreadyout_dflt),
      .hresp_dflt    (hresp_dflt)
   );

   typedef struct {
      string      sel_tag;
      string      rsp_tag;
      logic [3:0] sel;
      logic       dflt;
      logic       rdy;
      logic       resp;
   } exp_t;

   exp_t exp_q[$];
   int   m_st = 0;  // 0 okay, 1 first error cycle, 2 second error cycle

   // expected decode from the map in R1 with the priority of R4
   function automatic logic [4:0] ref_sel(input logic [31:0] a);
      logic [31:0] lo [4];
      logic [31:0] sz [4];
      lo = '{32'h0000_0000, 32'h0000_0800, 32'h0001_0000, 32'h0002_0000};
      sz = '{32'h1000, 32'h1000, 32'h0400, 32'h0800};
      for (int i = 0; i < 4; i++) begin
         if (a >= lo[i] && a - lo[i] < sz[i]) return {1'b0, 4'(1 << i)};
      end
      return 5'b1_0000;
   endfunction

   task automatic drive(input string st, input string rt, input logic [31:0] a,
                        input logic [1:0] t, input logic r);
      exp_t       e;
      logic [4:0] s;
      @(posedge hclk);
      #2;
      haddr  = a;
      htrans = t;
      hready = r;
      s = ref_sel(a);
      e.sel_tag = st;
      e.rsp_tag = rt;
      e.sel  = s[3:0];
      e.dflt = s[4];
      e.rdy  = (m_st != 1);
      e.resp = (m_st != 0);
      exp_q.push_back(e);
      if (m_st == 1)                m_st = 2;
      else if (s[4] && r && t[1])   m_st = 1;
      else                          m_st = 0;
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge hclk);
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_tests++;
            if (hsel !== e.sel || hsel_dflt !== e.dflt) begin
               n_fail++;
               $display("FAIL %s select at %h: got %b/%b expected %b/%b",
                        e.sel_tag, haddr, hsel, hsel_dflt, e.sel, e.dflt);
            end
            n_tests++;
            if (hreadyout_dflt !== e.rdy || hresp_dflt !== e.resp) begin
               n_fail++;
               $display("FAIL %s response: got rdy=%b resp=%b expected rdy=%b resp=%b",
                        e.rsp_tag, hreadyout_dflt, hresp_dflt, e.rdy, e.resp);
            end
            n_tests++;
            if ($countones({hsel, hsel_dflt}) != 1) begin
               n_fail++;
               $display("FAIL R5 one-hot: got %b expected exactly one bit",
                        {hsel, hsel_dflt});
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (5000) @(posedge hclk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge hclk);
      @(negedge hclk);
      n_tests++;
      if (hreadyout_dflt !== 1'b1 || hresp_dflt !== 1'b0) begin
         n_fail++;
         $display("FAIL R10 reset: got rdy=%b resp=%b expected rdy=1 resp=0",
                  hreadyout_dflt, hresp_dflt);
      end
      @(posedge hclk);
      #2 hresetn = 1'b1;

      // region edges and defaults
      drive("R1", "R10", 32'h0000_0000, 2'b00, 1'b1);
      drive("R1", "R6",  32'h0000_0FFC, 2'b00, 1'b1);
      drive("R4", "R6",  32'h0000_0800, 2'b00, 1'b1);
      drive("R4", "R6",  32'h0000_0C00, 2'b00, 1'b1);
      drive("R1", "R6",  32'h0000_1000, 2'b00, 1'b1);
      drive("R2", "R6",  32'h0000_17FC, 2'b00, 1'b1);
      drive("R3", "R6",  32'h0000_1800, 2'b00, 1'b1);
      drive("R2", "R6",  32'h0001_0000, 2'b00, 1'b1);
      drive("R2", "R6",  32'h0001_03FC, 2'b00, 1'b1);
      drive("R3", "R6",  32'h0001_0400, 2'b00, 1'b1);
      drive("R1", "R6",  32'h0002_0000, 2'b00, 1'b1);
      drive("R1", "R6",  32'h0002_07FC, 2'b00, 1'b1);
      drive("R3", "R6",  32'h0002_0800, 2'b00, 1'b1);
      drive("R3", "R6",  32'hFFFF_FFFC, 2'b00, 1'b1);

      // default responder behaviour
      drive("R3", "R6",  32'h0000_1800, 2'b01, 1'b1);  // BUSY
      drive("R9", "R6",  32'h0000_1800, 2'b10, 1'b0);  // NONSEQ while stalled
      drive("R3", "R8",  32'h0000_1800, 2'b10, 1'b1);  // accepted NONSEQ
      drive("R3", "R7",  32'h0000_1800, 2'b00, 1'b0);  // first error cycle
      drive("R3", "R7",  32'h0000_1800, 2'b11, 1'b1);  // second cycle, new SEQ
      drive("R9", "R7",  32'h0000_1800, 2'b00, 1'b0);
      drive("R1", "R7",  32'h0000_0000, 2'b10, 1'b1);  // mapped NONSEQ
      drive("R9", "R7",  32'h0000_0000, 2'b11, 1'b0);
      drive("R9", "R6",  32'h0000_1000, 2'b01, 1'b0);
      drive("R1", "R6",  32'h0000_0000, 2'b00, 1'b1);
      drive("R3", "R6",  32'h0003_0000, 2'b00, 1'b1);

      wait (exp_q.size() == 0);
      @(negedge hclk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule